// File: doc/BRIEF.md
# IrDA SIR Pulse Encoder

This block sits between a UART transmit line and an infrared LED driver. It watches the serial level on its input. Each bit cell that carries a 0 becomes one short light pulse, and a cell that carries a 1 leaves the LED dark. A baud divider input produces a tick at sixteen times the bit rate. The tick is 3.6864 MHz divided by (divider + 1), so a divider of 23 gives 9600 bps, 95 gives 2400 bps and 1 gives 115.2 kbps. One configuration bit chooses the pulse width: either a fixed short pulse of 6 clocks (about 1.6 µs at 3.6864 MHz) or three sixteenths of the bit cell.

Two timing policies are available. In the character-synchronous policy the block waits for the falling edge of a start bit and restarts its baud counter at that edge. It then samples every cell of the character at its middle and launches the pulses from its own ticks, so the pulses do not jitter with the UART clock. This policy needs the number of data bits per character. In the edge-triggered policy no framing is known: every falling edge launches a pulse at once. While the line stays low, one more pulse follows at each later cell boundary, timed by the internal baud counter.

The FSM has five states: IDLE, START, DATA, STOP and RUN. IDLE to START is a falling edge under the character-synchronous policy. IDLE to RUN is a falling edge under the edge-triggered policy. START goes back to IDLE when the line is high at the middle of the start cell (a false start). START goes to DATA at the end of the start cell. DATA goes to STOP at the end of the last data cell. STOP goes to IDLE at the middle of the stop cell. RUN goes to IDLE as soon as the line is high. Every state goes to IDLE when the transmitter is disabled.

Top module: `irda_sir_encoder`

## Requirements
- R1: After reset both LED outputs are high (off), and an idle high line produces no pulse.
- R2: Within a character, each cell at level 0 produces exactly one pulse, and each cell at level 1 produces none.
- R3: With `cfg_wide_pulse`=0, each pulse holds the enabled LED outputs low for exactly 6 clock cycles.
- R4: With `cfg_wide_pulse`=1, each pulse holds the enabled LED outputs low for exactly 3×(`cfg_baud_div`+1) clock cycles.
- R5: A bit cell lasts 16×(`cfg_baud_div`+1) clock cycles, and pulses of successive cells are spaced by exactly that amount.
- R6: With `cfg_char_sync`=1, the pulse for cell i starts at E+1+8×(div+1)+i×16×(div+1). Here E is the first clock edge that sees the start bit low, and "starts" means the LED outputs are low after that clock edge.
- R7: `cfg_char_len` codes 0, 1, 2 and 3 set 6, 7, 8 and 9 data bits. A line held low through a whole character gives exactly 1+N pulses, because a low stop cell gives no pulse and no new character starts without a new falling edge.
- R8: In the character-synchronous policy, a low level that ends before the middle of the start cell produces no pulse.
- R9: With `cfg_char_sync`=0, a falling edge at clock edge E starts a pulse at E+1. While the line stays low, further pulses start at E+1+k×16×(div+1).
- R10: `cfg_led_sel` bit 0 enables `led1_n` and bit 1 enables `led2_n`, so the codes 0 to 3 select none, output 1, output 2, or both. A disabled output stays high.
- R11: While `tx_en` is 0, both LED outputs are high one cycle later and a character in progress is abandoned. After `tx_en` returns, the next character is encoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (3.6864 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| ser_in | input | 1 | Serial data level from the UART |
| cfg_baud_div | input | DIV_W | Baud divider; tick period is value+1 clocks |
| cfg_wide_pulse | input | 1 | 0: fixed 6-clock pulse, 1: 3/16 of the cell |
| cfg_char_sync | input | 1 | 1: character-synchronous, 0: edge-triggered |
| cfg_char_len | input | 2 | Data bits per character, 6 plus the code |
| cfg_led_sel | input | 2 | Output enables: bit 0 for LED 1, bit 1 for LED 2 |
| led1_n | output | 1 | LED driver 1 enable, active low |
| led2_n | output | 1 | LED driver 2 enable, active low |

## Verification
Two situations are hard to reach from the ports. The first is a low stop cell in the character-synchronous policy: the line must stay low past the last data cell, and the FSM must then stay idle with no new falling edge. The bench holds the line low for three cells longer than each character length and counts the pulses for every length code. The second is a start bit that dies before its middle sample. A short low glitch drives it, and the bench confirms that no pulse follows. In the same way, dropping `tx_en` part-way through a frame and then sending a fresh character shows that the abandoned state does not leak into the next frame.

// File: rtl/irda_enc_pkg.sv
package irda_enc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_RUN
    } enc_state_t;

    // data bits per character: codes 0..3 select 6..9
    function automatic logic [3:0] data_bits(input logic [1:0] code);
        return 4'd6 + {2'b00, code};
    endfunction

endpackage

// File: rtl/irda_baud_tick.sv
module irda_baud_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q >= div) && !restart;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/irda_pulse_shaper.sv
module irda_pulse_shaper #(
    parameter int FIXED_CLKS = 6,
    parameter int WIDE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic launch,
    input  logic tick,
    input  logic wide,
    output logic active
);
    localparam int MAXC  = (FIXED_CLKS > WIDE_TICKS) ? FIXED_CLKS : WIDE_TICKS;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            active <= 1'b0;
            cnt_q  <= '0;
        end else if (launch) begin
            active <= 1'b1;
            cnt_q  <= '0;
        end else if (active) begin
            if (wide) begin
                if (tick) begin
                    if (cnt_q == CNT_W'(WIDE_TICKS - 1))
                        active <= 1'b0;
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                if (cnt_q == CNT_W'(FIXED_CLKS - 1))
                    active <= 1'b0;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/irda_sir_encoder.sv
module irda_sir_encoder
    import irda_enc_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int OVERSAMPLE = 16,
    parameter int FIXED_CLKS = 6,
    parameter int WIDE_TICKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             ser_in,
    input  logic [DIV_W-1:0] cfg_baud_div,
    input  logic             cfg_wide_pulse,
    input  logic             cfg_char_sync,
    input  logic [1:0]       cfg_char_len,
    input  logic [1:0]       cfg_led_sel,
    output logic             led1_n,
    output logic             led2_n
);
    localparam int SUB_W = $clog2(OVERSAMPLE);
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVERSAMPLE / 2 - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

    enc_state_t       state_q, state_d;
    logic [SUB_W-1:0] sub_q, sub_d;
    logic [3:0]       bit_q, bit_d;
    logic             ser_q;
    logic             tick, restart, launch, pulse_on;
    logic             fall, mid_tick, end_tick;
    logic [3:0]       nbits;

    irda_baud_tick #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (cfg_baud_div),
        .restart (restart),
        .tick    (tick)
    );

    irda_pulse_shaper #(.FIXED_CLKS(FIXED_CLKS), .WIDE_TICKS(WIDE_TICKS)) u_shape (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!tx_en),
        .launch (launch),
        .tick   (tick),
        .wide   (cfg_wide_pulse),
        .active (pulse_on)
    );

    assign nbits    = data_bits(cfg_char_len);
    assign fall     = ser_q && !ser_in;
    assign mid_tick = tick && (sub_q == SUB_MID);
    assign end_tick = tick && (sub_q == SUB_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sub_q   <= '0;
            bit_q   <= '0;
            ser_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            sub_q   <= sub_d;
            bit_q   <= bit_d;
            ser_q   <= ser_in;
        end
    end

    // next state, launch and phase restart
    always_comb begin
        state_d = state_q;
        sub_d   = tick ? sub_q + 1'b1 : sub_q;
        bit_d   = bit_q;
        launch  = 1'b0;
        restart = 1'b0;
        if (!tx_en) begin
            state_d = ST_IDLE;
            sub_d   = '0;
            bit_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sub_d = '0;
                    bit_d = '0;
                    if (fall) begin
                        restart = 1'b1;
                        if (cfg_char_sync)
                            state_d = ST_START;
                        else begin
                            state_d = ST_RUN;
                            launch  = 1'b1;
                        end
                    end
                end
                ST_START: begin
                    if (mid_tick) begin
                        if (ser_in) state_d = ST_IDLE;
                        else        launch  = 1'b1;
                    end else if (end_tick)
                        state_d = ST_DATA;
                end
                ST_DATA: begin
                    if (mid_tick && !ser_in)
                        launch = 1'b1;
                    if (end_tick) begin
                        bit_d = bit_q + 1'b1;
                        if (bit_q == nbits - 4'd1)
                            state_d = ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (mid_tick)
                        state_d = ST_IDLE;
                end
                ST_RUN: begin
                    if (ser_in)
                        state_d = ST_IDLE;
                    else if (end_tick)
                        launch = 1'b1;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led1_n <= 1'b1;
            led2_n <= 1'b1;
        end else begin
            led1_n <= !(pulse_on && tx_en && cfg_led_sel[0]);
            led2_n <= !(pulse_on && tx_en && cfg_led_sel[1]);
        end
    end
endmodule

// File: rtl/irda_sir_encoder_chk.sv
module irda_sir_encoder_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_en,
    input logic [DIV_W-1:0] cfg_baud_div,
    input logic             cfg_wide_pulse,
    input logic [1:0]       cfg_led_sel,
    input logic             led1_n,
    input logic             led2_n
);
    logic [15:0] run_q;
    logic [15:0] wide_len;

    assign wide_len = 16'((16'(cfg_baud_div) + 16'd1) * 16'd3);

    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (led1_n)
            run_q <= '0;
        else if (run_q != 16'hFFFF)
            run_q <= run_q + 16'd1;
    end

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (led1_n && led2_n)); // R11

    AST_LED1_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_led_sel[0] |=> led1_n); // R10

    AST_LED2_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_led_sel[1] |=> led2_n); // R10

    AST_BOTH_NEED_SEL3: assert property (@(posedge clk) disable iff (!rst_n)
        (!led1_n && !led2_n) |-> ($past(cfg_led_sel) == 2'b11)); // R10

    AST_FIXED_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(led1_n) && $past(tx_en) && !cfg_wide_pulse) |-> (run_q == 16'd6)); // R3

    AST_WIDE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(led1_n) && $past(tx_en) && cfg_wide_pulse) |-> (run_q == wide_len)); // R4
endmodule

bind irda_sir_encoder irda_sir_encoder_chk #(.DIV_W(DIV_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_en          (tx_en),
    .cfg_baud_div   (cfg_baud_div),
    .cfg_wide_pulse (cfg_wide_pulse),
    .cfg_led_sel    (cfg_led_sel),
    .led1_n         (led1_n),
    .led2_n         (led2_n)
);

// File: tb/irda_sir_encoder_tb.sv
module irda_sir_encoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       ser_in = 1'b1;
    logic [7:0] cfg_baud_div = 8'd1;
    logic       cfg_wide_pulse = 1'b0;
    logic       cfg_char_sync = 1'b1;
    logic [1:0] cfg_char_len = 2'd2;
    logic [1:0] cfg_led_sel = 2'd1;
    logic       led1_n, led2_n;

    irda_sir_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ser_in(ser_in),
        .cfg_baud_div(cfg_baud_div), .cfg_wide_pulse(cfg_wide_pulse),
        .cfg_char_sync(cfg_char_sync), .cfg_char_len(cfg_char_len),
        .cfg_led_sel(cfg_led_sel), .led1_n(led1_n), .led2_n(led2_n)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;
    int fall_t[64];
    int wid[64];
    int nf = 0, nw = 0, nf2 = 0, cur_w = 0;
    logic prev1 = 1'b1, prev2 = 1'b1;

    always @(posedge clk) cyc = cyc + 1;

    always @(negedge clk) begin
        if (!led1_n && prev1) begin
            if (nf < 64) fall_t[nf] = cyc;
            nf = nf + 1;
        end
        if (!led1_n) cur_w = cur_w + 1;
        if (led1_n && !prev1) begin
            if (nw < 64) wid[nw] = cur_w;
            nw = nw + 1;
            cur_w = 0;
        end
        if (!led2_n && prev2) nf2 = nf2 + 1;
        prev1 = led1_n;
        prev2 = led2_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int cell_len();
        return 16 * (int'(cfg_baud_div) + 1);
    endfunction

    task automatic clear_rec();
        nf = 0; nw = 0; nf2 = 0; cur_w = 0;
    endtask

    task automatic idle_cells(input int n);
        repeat (n * cell_len()) @(negedge clk);
    endtask

    task automatic send_line(input logic [15:0] line, input int nb, output int e);
        @(negedge clk);
        e = cyc + 1;
        for (int i = 0; i < nb; i++) begin
            ser_in = line[i];
            repeat (cell_len()) @(negedge clk);
        end
        ser_in = 1'b1;
    endtask

    function automatic logic [15:0] frame(input logic [8:0] data, input int nbits);
        logic [15:0] l = '0;
        for (int i = 0; i < nbits; i++) l[i+1] = data[i];
        l[nbits+1] = 1'b1;
        return l;
    endfunction

    // compare recorded pulses with the cells at level 0
    task automatic verify(input string req, input logic [15:0] line, input int nb,
                          input int e, input int ofs, input int pw);
        int k = 0;
        int bad_t = 0, bad_w = 0;
        int at = 0, et = 0, aw = 0;
        for (int i = 0; i < nb; i++) begin
            if (!line[i]) begin
                if (k < nf && k < 64 && bad_t == 0 && fall_t[k] != e + ofs + i * cell_len()) begin
                    bad_t = 1; at = fall_t[k]; et = e + ofs + i * cell_len();
                end
                if (k < nw && k < 64 && bad_w == 0 && wid[k] != pw) begin
                    bad_w = 1; aw = wid[k];
                end
                k++;
            end
        end
        chk(nf == k, {req, " R2 pulse count"}, nf, k);
        chk(bad_t == 0, {req, " pulse start"}, at, et);
        chk(bad_w == 0, {req, " pulse width"}, aw, pw);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int e;
        logic [15:0] l;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        tx_en = 1'b1;
        @(negedge clk);
        // R1: reset state and quiet idle line
        chk(led1_n == 1'b1, "R1 led1 after reset", led1_n, 1);
        chk(led2_n == 1'b1, "R1 led2 after reset", led2_n, 1);
        clear_rec();
        repeat (200) @(negedge clk);
        chk(nf == 0 && nf2 == 0, "R1 idle line pulses", nf + nf2, 0);

        // R6 R3: char-sync, fixed width, div 1
        cfg_baud_div = 8'd1; cfg_wide_pulse = 0; cfg_char_sync = 1; cfg_char_len = 2'd2;
        clear_rec(); l = frame(9'h0A5, 8);
        send_line(l, 10, e); idle_cells(2);
        verify("R6 R3", l, 10, e, 1 + 8 * 2, 6);

        // R4 R5: char-sync, wide pulse, div 3
        cfg_baud_div = 8'd3; cfg_wide_pulse = 1;
        clear_rec(); l = frame(9'h03C, 8);
        send_line(l, 10, e); idle_cells(2);
        verify("R4 R5", l, 10, e, 1 + 8 * 4, 12);

        // R7: low line through the whole character, every length code
        cfg_baud_div = 8'd1; cfg_wide_pulse = 0;
        for (int c = 0; c < 4; c++) begin
            cfg_char_len = c[1:0];
            clear_rec();
            send_line(16'h0000, 6 + c + 3, e); idle_cells(2);
            chk(nf == 7 + c, "R7 pulses for length code", nf, 7 + c);
        end
        cfg_char_len = 2'd2;

        // R8: short low glitch is a false start
        clear_rec();
        @(negedge clk); ser_in = 0;
        repeat (4 * 2) @(negedge clk); ser_in = 1;
        idle_cells(2);
        chk(nf == 0, "R8 false start pulses", nf, 0);

        // R9: edge-triggered, fixed and wide
        cfg_char_sync = 0;
        for (int w = 0; w < 2; w++) begin
            cfg_wide_pulse = w[0];
            clear_rec(); l = frame(9'h00F, 8);
            send_line(l, 10, e); idle_cells(2);
            verify("R9", l, 10, e, 1, w ? 6 : 6);
        end
        cfg_wide_pulse = 0;
        cfg_baud_div = 8'd2;
        cfg_wide_pulse = 1;
        clear_rec(); l = frame(9'h092, 8);
        send_line(l, 10, e); idle_cells(2);
        verify("R9 R4", l, 10, e, 1, 9);
        cfg_wide_pulse = 0; cfg_baud_div = 8'd1; cfg_char_sync = 1;

        // R10: output select sweep with an all-zero byte (9 pulses)
        for (int s = 0; s < 4; s++) begin
            cfg_led_sel = s[1:0];
            clear_rec(); l = frame(9'h000, 8);
            send_line(l, 10, e); idle_cells(2);
            chk(nf == (s[0] ? 9 : 0), "R10 led1 pulses", nf, s[0] ? 9 : 0);
            chk(nf2 == (s[1] ? 9 : 0), "R10 led2 pulses", nf2, s[1] ? 9 : 0);
        end
        cfg_led_sel = 2'd1;

        // R11: drop enable after three cells, then send a fresh character
        clear_rec();
        @(negedge clk); e = cyc + 1; ser_in = 0;
        repeat (3 * cell_len()) @(negedge clk);
        tx_en = 0;
        @(negedge clk);
        chk(led1_n && led2_n, "R11 leds off when disabled", {led1_n, led2_n}, 3);
        repeat (7 * cell_len()) @(negedge clk);
        ser_in = 1;
        idle_cells(1);
        chk(nf == 3, "R11 pulses before drop only", nf, 3);
        tx_en = 1;
        idle_cells(1);
        clear_rec(); l = frame(9'h0FF, 8);
        send_line(l, 10, e); idle_cells(2);
        verify("R11", l, 10, e, 1 + 8 * 2, 6);

        // R5 R6: default 9600 divider
        cfg_baud_div = 8'd23;
        clear_rec(); l = frame(9'h055, 8);
        send_line(l, 10, e); idle_cells(2);
        verify("R5 R6", l, 10, e, 1 + 8 * 24, 6);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule